// File: doc/BRIEF.md
# Sleep-Mode Clock Domain Controller

This block manages power for a small microcontroller-style system. A 3-bit sleep-mode code and a one-cycle sleep request move it from running into one of five sleep states. In each state it drives enables for six clock domains (CPU, flash, general I/O, converter, asynchronous, and a sleep-time synchronous feed for the display and 8-bit timer) and for two oscillators: the main oscillator and the low-frequency timer oscillator. Each state honours its own set of wake inputs. Short sleeps return to running on the next edge. Deep sleeps return through a counted wake sequence.

The display controller and the 8-bit timer each choose either the asynchronous clock or the synchronous clock. In Power-save, that choice decides which oscillator keeps running. A bus-visible power reduction register can stop the clock of five peripherals one at a time. While a peripheral's clock is stopped, its register writes are suppressed and its reads return zero. Every domain clock and peripheral clock leaves the block through a latch-based gating cell. The latch is transparent only while the clock is low, so the enable never changes during the high phase.

Top module: `slpclk_ctrl`

## Requirements
- R1: After reset the state is Active. `dom_en` is 6'b001111, with bit 4 also set if either peripheral selects the asynchronous clock. `osc_main_en` is 1, `osc_lf_en` equals that asynchronous selection, the reduction register reads 0x00 and `per_en` is 5'b11111.
- R2: A `slp_req` pulse in Active takes `slp_mode` and enters a state on the next edge. The codes are 3'b000 Idle, 3'b001 ADC Noise Reduction, 3'b010 Power-down, 3'b011 Power-save and 3'b110 Standby. Any other code leaves the block in Active.
- R3: Idle clears CPU and flash (`dom_en` bits 0 and 1) and keeps I/O and ADC (bits 2 and 3). Any of `wk_ext`, `wk_async`, `wk_adc` or `wk_io` returns the block to Active on the next edge.
- R4: ADC Noise Reduction keeps only the ADC domain (bit 3) and the asynchronous domain. `wk_ext`, `wk_async` and `wk_adc` wake it on the next edge. `wk_io` is ignored.
- R5: Power-down clears every domain enable and both oscillator enables. Only `wk_ext` wakes it. CPU enable returns exactly WAKE_PD_CYC edges after the edge that sampled the wake.
- R6: In Power-save, the asynchronous domain (bit 4) and `osc_lf_en` are 1 only if `lcd_async` or `tmr_async` is set. The synchronous feed (bit 5) and `osc_main_en` are 1 only if at least one of them is clear. `wk_ext` and `wk_async` wake it, with WAKE_PD_CYC latency.
- R7: Standby equals Power-down except that `osc_main_en` stays 1. Its wake completes in exactly WAKE_SB_CYC (default 6) edges. Code 3'b110 enters Standby only when `xtal_osc` is 1; otherwise it enters Power-down.
- R8: The reduction register sits at `io_sel` = 5. The bit map is 4 display, 3 16-bit timer, 2 SPI, 1 USART, 0 ADC. Bits 7..5 read as zero and ignore writes.
- R9: In Active and Idle, `per_en[i]` is the inverse of reduction bit i.
- R10: When `io_sel` = i (0..4) and bit i is set, `io_wr` gives no `periph_wr[i]` strobe and `io_rdata` is zero. When the bit is clear, the strobe fires and `io_rdata` returns byte i of `periph_rdata`. Clearing the bit restores both.
- R11: Outside Active and Idle, the register has no effect. `per_en` is 5'b00001 in ADC Noise Reduction, 5'b10000 in Power-save and 0 otherwise.
- R12: `dom_gclk` and `per_gclk` are low while `clk` is low. While `clk` is high they equal the enables that held through the preceding low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp_mode | input | 3 | Sleep-mode code |
| slp_req | input | 1 | One-cycle sleep request |
| xtal_osc | input | 1 | External crystal/resonator configured |
| lcd_async | input | 1 | Display controller uses the asynchronous clock |
| tmr_async | input | 1 | 8-bit timer uses the asynchronous clock |
| wk_ext | input | 1 | External level / pin-change wake |
| wk_async | input | 1 | Asynchronous-peripheral wake |
| wk_adc | input | 1 | Converter-complete wake |
| wk_io | input | 1 | Other I/O wake |
| io_sel | input | 3 | Register target: 0..4 peripheral, 5 reduction register |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| periph_rdata | input | 40 | Peripheral read bytes, byte i at bits 8i+7:8i |
| io_rdata | output | 8 | Read data |
| periph_wr | output | 5 | Per-peripheral write strobes |
| dom_en | output | 6 | Domain enables: cpu, flash, io, adc, async, sleep-sync |
| dom_gclk | output | 6 | Gated domain clocks |
| per_en | output | 5 | Peripheral clock enables |
| per_gclk | output | 5 | Gated peripheral clocks |
| osc_main_en | output | 1 | Main oscillator enable |
| osc_lf_en | output | 1 | Low-frequency timer oscillator enable |

## Verification
The bench sweeps all eight mode codes against both crystal settings and all four clock-source combinations. For each case it checks the entry pattern and measures the wake latency edge by edge. A design that miscounts the wake sequence would bring the CPU enable back one edge early or late. A design that ignores `xtal_osc` would enter Standby and leave the main oscillator running. A wrong Power-save choice would keep the wrong oscillator on. The bench also offers each deep state wake inputs it must ignore. It then checks reduction-register masking, including reserved bits, suppressed strobes and zeroed reads, and checks that the register has no effect in ADC Noise Reduction.

// File: rtl/slpclk_pkg.sv
package slpclk_pkg;
    typedef enum logic [2:0] {
        S_ACTIVE, S_IDLE, S_ADCNR, S_PDOWN, S_PSAVE, S_STBY, S_WAKE
    } pm_state_t;

    localparam logic [2:0] MC_IDLE  = 3'b000;
    localparam logic [2:0] MC_ADCNR = 3'b001;
    localparam logic [2:0] MC_PDOWN = 3'b010;
    localparam logic [2:0] MC_PSAVE = 3'b011;
    localparam logic [2:0] MC_STBY  = 3'b110;

    localparam int N_DOM = 6;
    localparam int N_PER = 5;
    localparam int D_CPU = 0, D_FLASH = 1, D_IO = 2, D_ADC = 3, D_ASY = 4, D_SYN = 5;
endpackage

// File: rtl/slpclk_gate.sv
module slpclk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_l;

    always_latch begin
        if (!clk) en_l = en;
    end

    assign gclk = clk & en_l;
endmodule

// File: rtl/slpclk_prr.sv
module slpclk_prr #(
    parameter int DW = 8,
    parameter int NP = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [NP-1:0] prr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     prr <= '0;
        else if (wr_en) prr <= wdata[NP-1:0];
    end
endmodule

// File: rtl/slpclk_fsm.sv
module slpclk_fsm
    import slpclk_pkg::*;
#(
    parameter int WAKE_PD_CYC = 16,
    parameter int WAKE_SB_CYC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       slp_mode,
    input  logic             slp_req,
    input  logic             xtal_osc,
    input  logic             lcd_async,
    input  logic             tmr_async,
    input  logic             wk_ext,
    input  logic             wk_async,
    input  logic             wk_adc,
    input  logic             wk_io,
    output pm_state_t        st,
    output logic [N_DOM-1:0] dom_en,
    output logic             osc_main_en,
    output logic             osc_lf_en
);
    localparam int WMAX = (WAKE_PD_CYC > WAKE_SB_CYC) ? WAKE_PD_CYC : WAKE_SB_CYC;
    localparam int CW   = $clog2(WMAX);
    localparam logic [CW-1:0] PD_LD = CW'(WAKE_PD_CYC - 2);
    localparam logic [CW-1:0] SB_LD = CW'(WAKE_SB_CYC - 2);

    pm_state_t     nxt;
    logic [CW-1:0] cnt, cnt_d;
    logic          any_asy, any_syn;

    assign any_asy = lcd_async | tmr_async;
    assign any_syn = ~lcd_async | ~tmr_async;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= S_ACTIVE;
            cnt <= '0;
        end else begin
            st  <= nxt;
            cnt <= cnt_d;
        end
    end

    always_comb begin
        nxt   = st;
        cnt_d = cnt;
        unique case (st)
            S_ACTIVE: if (slp_req) begin
                case (slp_mode)
                    MC_IDLE:  nxt = S_IDLE;
                    MC_ADCNR: nxt = S_ADCNR;
                    MC_PDOWN: nxt = S_PDOWN;
                    MC_PSAVE: nxt = S_PSAVE;
                    MC_STBY:  nxt = xtal_osc ? S_STBY : S_PDOWN;
                    default:  nxt = S_ACTIVE;
                endcase
            end
            S_IDLE:  if (wk_ext | wk_async | wk_adc | wk_io) nxt = S_ACTIVE;
            S_ADCNR: if (wk_ext | wk_async | wk_adc) nxt = S_ACTIVE;
            S_PDOWN: if (wk_ext) begin
                nxt = S_WAKE; cnt_d = PD_LD;
            end
            S_PSAVE: if (wk_ext | wk_async) begin
                nxt = S_WAKE; cnt_d = PD_LD;
            end
            S_STBY: if (wk_ext) begin
                nxt = S_WAKE; cnt_d = SB_LD;
            end
            S_WAKE: begin
                if (cnt == '0) nxt = S_ACTIVE;
                else           cnt_d = cnt - 1'b1;
            end
            default: nxt = S_ACTIVE;
        endcase
    end

    always_comb begin
        dom_en      = '0;
        osc_main_en = 1'b0;
        osc_lf_en   = 1'b0;
        unique case (st)
            S_ACTIVE: begin
                dom_en[D_CPU] = 1'b1; dom_en[D_FLASH] = 1'b1;
                dom_en[D_IO]  = 1'b1; dom_en[D_ADC]   = 1'b1;
                dom_en[D_ASY] = any_asy; osc_main_en = 1'b1; osc_lf_en = any_asy;
            end
            S_IDLE: begin
                dom_en[D_IO] = 1'b1; dom_en[D_ADC] = 1'b1;
                dom_en[D_ASY] = any_asy; osc_main_en = 1'b1; osc_lf_en = any_asy;
            end
            S_ADCNR: begin
                dom_en[D_ADC] = 1'b1;
                dom_en[D_ASY] = any_asy; osc_main_en = 1'b1; osc_lf_en = any_asy;
            end
            S_PSAVE: begin
                dom_en[D_ASY] = any_asy; dom_en[D_SYN] = any_syn;
                osc_main_en = any_syn; osc_lf_en = any_asy;
            end
            S_STBY:  osc_main_en = 1'b1;
            S_WAKE: begin
                dom_en[D_ASY] = any_asy; osc_main_en = 1'b1; osc_lf_en = any_asy;
            end
            default: ;
        endcase
    end

    AST_WAKE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAKE && cnt == '0) |=> (st == S_ACTIVE && dom_en[D_CPU]));  // R7
    AST_PDOWN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PDOWN && !wk_ext) |=> (dom_en == '0 && !osc_main_en && !osc_lf_en));  // R5
    AST_STBY_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ACTIVE && slp_req && slp_mode == MC_STBY && !xtal_osc) |=> !osc_main_en);  // R7
    AST_CPU_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_en[D_CPU]) |-> ($past(st) == S_WAKE || $past(st) == S_IDLE
                                  || $past(st) == S_ADCNR));  // R3
endmodule

// File: rtl/slpclk_ctrl.sv
module slpclk_ctrl
    import slpclk_pkg::*;
#(
    parameter int WAKE_PD_CYC = 16,
    parameter int WAKE_SB_CYC = 6,
    parameter int DW          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        slp_mode,
    input  logic              slp_req,
    input  logic              xtal_osc,
    input  logic              lcd_async,
    input  logic              tmr_async,
    input  logic              wk_ext,
    input  logic              wk_async,
    input  logic              wk_adc,
    input  logic              wk_io,
    input  logic [2:0]        io_sel,
    input  logic              io_wr,
    input  logic [DW-1:0]     io_wdata,
    input  logic [5*DW-1:0]   periph_rdata,
    output logic [DW-1:0]     io_rdata,
    output logic [4:0]        periph_wr,
    output logic [5:0]        dom_en,
    output logic [5:0]        dom_gclk,
    output logic [4:0]        per_en,
    output logic [4:0]        per_gclk,
    output logic              osc_main_en,
    output logic              osc_lf_en
);
    localparam logic [2:0] PRR_SEL = 3'd5;
    localparam int         NG      = N_DOM + N_PER;

    pm_state_t        st;
    logic [N_PER-1:0] prr;
    logic [NG-1:0]    g_en, g_clk;

    slpclk_fsm #(.WAKE_PD_CYC(WAKE_PD_CYC), .WAKE_SB_CYC(WAKE_SB_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .slp_mode(slp_mode), .slp_req(slp_req),
        .xtal_osc(xtal_osc), .lcd_async(lcd_async), .tmr_async(tmr_async),
        .wk_ext(wk_ext), .wk_async(wk_async), .wk_adc(wk_adc), .wk_io(wk_io),
        .st(st), .dom_en(dom_en), .osc_main_en(osc_main_en), .osc_lf_en(osc_lf_en)
    );

    slpclk_prr #(.DW(DW), .NP(N_PER)) u_prr (
        .clk(clk), .rst_n(rst_n), .wr_en(io_wr && io_sel == PRR_SEL),
        .wdata(io_wdata), .prr(prr)
    );

    always_comb begin
        unique case (st)
            S_ACTIVE, S_IDLE: per_en = ~prr;
            S_ADCNR:          per_en = 5'b00001;
            S_PSAVE:          per_en = 5'b10000;
            default:          per_en = '0;
        endcase
    end

    always_comb begin
        periph_wr = '0;
        io_rdata  = '0;
        if (io_sel == PRR_SEL) begin
            io_rdata = DW'(prr);
        end else if (io_sel < PRR_SEL) begin
            if (!prr[io_sel]) begin
                periph_wr[io_sel] = io_wr;
                io_rdata          = periph_rdata[io_sel*DW +: DW];
            end
        end
    end

    assign g_en = {per_en, dom_en};

    for (genvar gi = 0; gi < NG; gi++) begin : g_cell
        slpclk_gate u_gate (.clk(clk), .en(g_en[gi]), .gclk(g_clk[gi]));
    end

    assign dom_gclk = g_clk[N_DOM-1:0];
    assign per_gclk = g_clk[NG-1:N_DOM];

    AST_NO_GATED_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_wr & prr) == '0);  // R10
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel == PRR_SEL) |-> (io_rdata[DW-1:N_PER] == '0));  // R8
    AST_DEEP_PRR_IGN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PDOWN || st == S_STBY || st == S_WAKE) |-> (per_en == '0));  // R11
endmodule

// File: tb/slpclk_ctrl_bench.sv
module slpclk_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] slp_mode = '0;
    logic slp_req = 0, xtal_osc = 0, lcd_async = 0, tmr_async = 0;
    logic wk_ext = 0, wk_async = 0, wk_adc = 0, wk_io = 0;
    logic [2:0] io_sel = 3'd7;
    logic io_wr = 0;
    logic [7:0] io_wdata = '0;
    logic [39:0] periph_rdata = 40'hA5_3C_5A_C3_99;
    logic [7:0] io_rdata;
    logic [4:0] periph_wr, per_en, per_gclk;
    logic [5:0] dom_en, dom_gclk;
    logic osc_main_en, osc_lf_en;

    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    slpclk_ctrl u_slpclk_ctrl (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #5;
    endtask

    // state index: 0 active,1 idle,2 adcnr,3 pdown,4 psave,5 stby
    function automatic int state_of(input logic [2:0] m, input logic x);
        case (m)
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 3;
            3'b011: return 4;
            3'b110: return x ? 5 : 3;
            default: return 0;
        endcase
    endfunction

    // returns {lf, main, dom[5:0]}
    function automatic logic [7:0] exp_out(input int s, input logic la, input logic ta);
        logic a, y;
        a = la | ta;
        y = !la | !ta;
        case (s)
            0: return {a, 1'b1, 1'b0, a, 4'b1111};
            1: return {a, 1'b1, 1'b0, a, 4'b1100};
            2: return {a, 1'b1, 1'b0, a, 4'b1000};
            4: return {a, y, y, a, 4'b0000};
            5: return {1'b0, 1'b1, 6'b0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic int latency(input int s);
        case (s)
            1, 2: return 1;
            5: return 6;
            default: return 16;
        endcase
    endfunction

    function automatic string rtag(input int s);
        case (s)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic enter(input logic [2:0] m);
        slp_mode = m; slp_req = 1; tick(); slp_req = 0;
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n, s;
        logic [7:0] e;
        tick(); tick(); rst_n = 1; tick();
        io_sel = 3'd5;
        chk(dom_en == 6'b001111 && osc_main_en && !osc_lf_en, "R1 reset enables",
            {osc_lf_en, osc_main_en, dom_en}, 8'h4F);
        chk(io_rdata == 8'h00 && per_en == 5'h1F, "R1 reset reg", {io_rdata, 3'b0, per_en}, 16'h001F);
        io_sel = 3'd7;

        // sweep mode codes x crystal x clock-source selections
        for (int c = 0; c < 64; c++) begin
            slp_mode = c[2:0]; xtal_osc = c[3]; lcd_async = c[4]; tmr_async = c[5];
            s = state_of(c[2:0], c[3]);
            enter(c[2:0]);
            e = exp_out(s, c[4], c[5]);
            chk({osc_lf_en, osc_main_en, dom_en} == e, rtag(s),
                {osc_lf_en, osc_main_en, dom_en}, e);
            if (s == 0) continue;
            tick();
            chk(dom_gclk == dom_en && per_gclk == per_en, "R12 high phase", dom_gclk, dom_en);
            #10;
            chk(dom_gclk == 0 && per_gclk == 0, "R12 low phase", dom_gclk, 0);
            wk_ext = 1; tick(); wk_ext = 0; n = 1;
            while (!dom_en[0] && n < 40) begin tick(); n++; end
            chk(n == latency(s), {rtag(s), " wake latency"}, n, latency(s));
        end
        lcd_async = 0; tmr_async = 0; xtal_osc = 1;

        // wake filtering
        enter(3'b010);
        wk_async = 1; wk_adc = 1; wk_io = 1; tick(); wk_async = 0; wk_adc = 0; wk_io = 0;
        tick();
        chk(dom_en == 0, "R5 ignores non-ext wake", dom_en, 0);
        wk_ext = 1; tick(); wk_ext = 0; repeat (15) tick();
        enter(3'b110);
        wk_async = 1; tick(); wk_async = 0; tick();
        chk(dom_en == 0 && osc_main_en, "R7 ignores async wake", dom_en, 0);
        wk_ext = 1; tick(); wk_ext = 0; repeat (5) tick();
        chk(dom_en[0], "R7 back active", dom_en, 6'h0F);
        enter(3'b011);
        wk_async = 1; tick(); wk_async = 0; repeat (15) tick();
        chk(dom_en[0], "R6 async wake", dom_en, 6'h0F);
        enter(3'b001);
        wk_io = 1; tick(); wk_io = 0;
        chk(dom_en == 6'b001000, "R4 ignores io wake", dom_en, 6'h08);
        wk_adc = 1; tick(); wk_adc = 0;
        chk(dom_en == 6'b001111, "R4 adc wake", dom_en, 6'h0F);
        enter(3'b000);
        wk_io = 1; tick(); wk_io = 0;
        chk(dom_en == 6'b001111, "R3 io wake", dom_en, 6'h0F);

        // reduction register
        io_sel = 3'd5; io_wdata = 8'hFF; io_wr = 1; tick(); io_wr = 0;
        chk(io_rdata == 8'h1F, "R8 reserved bits", io_rdata, 8'h1F);
        io_wdata = 8'h15; io_wr = 1; tick(); io_wr = 0;
        chk(io_rdata == 8'h15, "R8 readback", io_rdata, 8'h15);
        chk(per_en == 5'h0A, "R9 active gating", per_en, 5'h0A);
        io_sel = 3'd7;
        enter(3'b000);
        chk(per_en == 5'h0A, "R9 idle gating", per_en, 5'h0A);
        wk_io = 1; tick(); wk_io = 0;
        io_sel = 3'd2; io_wr = 1; #1;
        chk(periph_wr == 0 && io_rdata == 0, "R10 blocked access", {periph_wr, io_rdata}, 0);
        io_sel = 3'd1; #1;
        chk(periph_wr == 5'b00010 && io_rdata == 8'hC3, "R10 open access", {periph_wr, io_rdata}, 13'h02C3);
        io_wr = 0;
        io_sel = 3'd5; io_wdata = 8'h11; io_wr = 1; tick(); io_wr = 0;
        io_sel = 3'd2; io_wr = 1; #1;
        chk(periph_wr == 5'b00100 && io_rdata == 8'h5A, "R10 restored", {periph_wr, io_rdata}, 13'h045A);
        io_wr = 0; io_sel = 3'd7;
        enter(3'b001);
        chk(per_en == 5'b00001, "R11 adcnr ignores reg", per_en, 1);
        wk_ext = 1; tick(); wk_ext = 0;
        enter(3'b011);
        chk(per_en == 5'b10000, "R11 psave ignores reg", per_en, 5'h10);
        wk_ext = 1; tick(); wk_ext = 0; repeat (15) tick();
        chk(per_en == 5'h0E, "R9 after return", per_en, 5'h0E);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule